// File: doc/BRIEF.md
# Pipeline Debug Halt Controller

This controller sits beside a five-stage in-order pipeline with branch delay slots and decides when execution stops for debugging. It holds a small bank of programmable instruction-address breakpoints and compares every fetched address against them. Decode also reports when the instruction it holds is a software break. Either condition puts a marker on the instruction, and the marker moves down with it through the controller's own copy of the stage occupancy. Nothing is taken at fetch. The controller acts only when a marked instruction reaches the memory stage.

When a marked instruction reaches memory, the controller flushes everything younger and stops fetch. It then waits for the pipeline to drain and raises `halted` in the cycle after the pipeline is found empty. An address-breakpoint hit also has its own memory access blocked and is removed before writeback. It reports a resume PC equal to its own address, or to the address of the branch in front of it when it sits in a delay slot. A software break retires normally and reports the address after itself. A debugger restarts the core with a one-cycle run or step pulse, and the pipeline reloads its fetch PC from `resume_pc` on that same edge. After an address-breakpoint halt, the first instruction fetched is exempt from matching, so execution can move past the breakpoint.

The state machine has four states. ST_HALT is entered from reset and from ST_DRAIN. ST_RUN is entered from ST_HALT on a run pulse. ST_STEP is entered from ST_HALT on a step pulse. ST_DRAIN is entered from ST_RUN or ST_STEP on a memory-stage event, and from ST_STEP once its single instruction has been fetched. The transitions are: ST_HALT to ST_RUN (run pulse, which wins over step); ST_HALT to ST_STEP (step pulse); ST_RUN to ST_DRAIN (event); ST_STEP to ST_DRAIN (event or accepted fetch); ST_DRAIN to ST_HALT (no event and pipeline empty).

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset the controller is in ST_HALT. `halted` is 1, `fetch_en`, `flush` and `mem_kill` are 0, and `resume_pc` equals the RESET_PC parameter.
- R2: A breakpoint entry matches a fetch only when its enable bit is set and its address equals `if_pc` on bits 31:2. Bits 1:0 are ignored, and a disabled entry never matches.
- R3: When an instruction marked by an address breakpoint is in the memory stage, `mem_kill` and `flush` are 1 for that cycle and `fetch_en` is 0. The instruction never reaches writeback.
- R4: After an address-breakpoint halt, `resume_pc` is the marked instruction's address. If `if_dslot` was 1 when it was fetched, `resume_pc` is instead the `if_br_pc` given with it.
- R5: An instruction that is in decode while `id_brk` is 1 becomes a software break. It raises `flush` without `mem_kill` in the memory stage, still retires, and yields `resume_pc` equal to its address plus 4.
- R6: When several marked instructions are in flight, only the oldest acts. A marker on an instruction flushed by an older event has no effect on `resume_pc` or `mem_kill`.
- R7: `halted` rises one cycle after the tracked stages are all empty. Counted from the cycle `flush` is high, `halted` is seen 2 cycles later for an address breakpoint and 3 cycles later for a software break.
- R8: `halted` stays 1 and `resume_pc` stays unchanged until a `run_req` or `step_req` pulse. The pulse moves the controller out of ST_HALT on that edge.
- R9: A step pulse lets exactly one fetch be accepted. The controller then halts again with `resume_pc` equal to `pc_next` as it stands when the pipeline is empty.
- R10: After an address-breakpoint halt, the first accepted fetch ignores all breakpoints. Every later fetch is compared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_wr | input | 1 | Write strobe for one breakpoint entry |
| bp_idx | input | 2 | Entry selected by the write |
| bp_addr | input | 32 | Address written to the entry |
| bp_en | input | 1 | Enable bit written to the entry |
| if_valid | input | 1 | Fetch stage offers an instruction |
| if_pc | input | 32 | Address of the offered instruction |
| if_dslot | input | 1 | Offered instruction sits in a delay slot |
| if_br_pc | input | 32 | Address of the branch owning that slot |
| id_brk | input | 1 | Decode holds a software break instruction |
| pc_next | input | 32 | Address the fetch unit would fetch next |
| run_req | input | 1 | One-cycle request to resume execution |
| step_req | input | 1 | One-cycle request to execute one instruction |
| fetch_en | output | 1 | Fetch may accept an instruction this cycle |
| flush | output | 1 | Discard all instructions younger than memory |
| mem_kill | output | 1 | Block the memory-stage access and its retirement |
| halted | output | 1 | Core is stopped for debug |
| resume_pc | output | 32 | Address to restart fetch from |

## Verification
The main function is exercised with a table of programs. Each program varies where the breakpoint sits, whether it is enabled, whether it lies in a delay slot, and where a software break sits relative to it. Comparing `resume_pc` and the `mem_kill` count across these cases separates the address path from the software path, the delay-slot substitution from the plain address, and the older event from a younger one. The halt latency after `flush` separates a killed instruction from one that retires. Directed runs around a breakpoint check the one-shot exemption (continue past, then stop again on a fresh pass) and a single step taken from a breakpoint halt.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic [1:0] {
        XK_NONE = 2'd0,
        XK_ADDR = 2'd1,
        XK_SOFT = 2'd2
    } xkind_t;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_STEP  = 2'd2,
        ST_DRAIN = 2'd3
    } dstate_t;

    typedef struct packed {
        logic        v;
        xkind_t      kind;
        logic        dslot;
        logic [31:0] pc;
        logic [31:0] br_pc;
    } stage_t;

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
    parameter int NUM_BP = 4,
    parameter int AW     = 32,
    localparam int IDXW  = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_en,
    input  logic [AW-1:0]   fetch_pc,
    input  logic            mask,
    output logic            hit
);
    localparam logic [AW-1:0] CMP_MASK = ~AW'(3);

    logic [AW-1:0]     addr_q [NUM_BP];
    logic [NUM_BP-1:0] en_q;
    logic [NUM_BP-1:0] eq;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (wr && wr_idx == IDXW'(g)) begin
                addr_q[g] <= wr_addr;
                en_q[g]   <= wr_en;
            end
        end
        assign eq[g] = en_q[g] && (((addr_q[g] ^ fetch_pc) & CMP_MASK) == '0);
    end

    assign hit = (|eq) && !mask;

endmodule

// File: rtl/dbg_tag_pipe.sv
module dbg_tag_pipe
    import dbg_halt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fire,
    input  logic   hit,
    input  logic [31:0] if_pc,
    input  logic   if_dslot,
    input  logic [31:0] if_br_pc,
    input  logic   id_brk,
    input  logic   flush,
    output stage_t mem_q,
    output logic   empty
);
    stage_t id_q, ex_q;
    logic   wb_v;
    stage_t id_d, ex_d;

    always_comb begin
        id_d       = '0;
        id_d.v     = fire && !flush;
        id_d.kind  = hit ? XK_ADDR : XK_NONE;
        id_d.dslot = if_dslot;
        id_d.pc    = if_pc;
        id_d.br_pc = if_br_pc;
        if (!id_d.v) begin
            id_d = '0;
        end
    end

    always_comb begin
        ex_d = id_q;
        if (id_q.v && id_q.kind == XK_NONE && id_brk) begin
            ex_d.kind = XK_SOFT;
        end
        if (flush) begin
            ex_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            ex_q  <= '0;
            mem_q <= '0;
            wb_v  <= 1'b0;
        end else begin
            id_q  <= id_d;
            ex_q  <= ex_d;
            mem_q <= flush ? '0 : ex_q;
            wb_v  <= mem_q.v && !(flush && mem_q.kind == XK_ADDR);
        end
    end

    assign empty = !id_q.v && !ex_q.v && !mem_q.v && !wb_v;

endmodule

// File: rtl/dbg_halt_fsm.sv
module dbg_halt_fsm
    import dbg_halt_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  stage_t      mem_q,
    input  logic        empty,
    input  logic        if_valid,
    input  logic [31:0] pc_next,
    input  logic        run_req,
    input  logic        step_req,
    output logic        fetch_en,
    output logic        flush,
    output logic        mem_kill,
    output logic        halted,
    output logic [31:0] resume_pc,
    output logic        mask_arm
);
    dstate_t state_q, state_d;
    logic    evt;
    logic    evt_seen_q;

    assign evt = mem_q.v && mem_q.kind != XK_NONE;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (run_req)       state_d = ST_RUN;
                else if (step_req) state_d = ST_STEP;
            end
            ST_RUN: begin
                if (evt) state_d = ST_DRAIN;
            end
            ST_STEP: begin
                if (evt || if_valid) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!evt && empty) state_d = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        fetch_en = 1'b0;
        flush    = 1'b0;
        mem_kill = 1'b0;
        halted   = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                halted = 1'b1;
            end
            ST_RUN, ST_STEP: begin
                fetch_en = !evt;
                flush    = evt;
                mem_kill = evt && mem_q.kind == XK_ADDR;
            end
            ST_DRAIN: begin
                flush    = evt;
                mem_kill = evt && mem_q.kind == XK_ADDR;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resume_pc  <= RESET_PC;
            evt_seen_q <= 1'b0;
            mask_arm   <= 1'b0;
        end else begin
            if (fetch_en && if_valid) begin
                mask_arm <= 1'b0;
            end
            if (evt) begin
                evt_seen_q <= 1'b1;
                mask_arm   <= (mem_q.kind == XK_ADDR);
                if (mem_q.kind == XK_ADDR) begin
                    resume_pc <= mem_q.dslot ? mem_q.br_pc : mem_q.pc;
                end else begin
                    resume_pc <= mem_q.pc + 32'd4;
                end
            end else if (state_q == ST_DRAIN && empty && !evt_seen_q) begin
                resume_pc <= pc_next;
            end
            if (state_q == ST_HALT && (run_req || step_req)) begin
                evt_seen_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int          NUM_BP   = 4,
    parameter logic [31:0] RESET_PC = 32'h0000_0000,
    localparam int         IDXW     = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bp_wr,
    input  logic [IDXW-1:0] bp_idx,
    input  logic [31:0]     bp_addr,
    input  logic            bp_en,
    input  logic            if_valid,
    input  logic [31:0]     if_pc,
    input  logic            if_dslot,
    input  logic [31:0]     if_br_pc,
    input  logic            id_brk,
    input  logic [31:0]     pc_next,
    input  logic            run_req,
    input  logic            step_req,
    output logic            fetch_en,
    output logic            flush,
    output logic            mem_kill,
    output logic            halted,
    output logic [31:0]     resume_pc
);
    logic   hit;
    logic   mask_arm;
    logic   pipe_empty;
    stage_t mem_q;

    dbg_bp_match #(.NUM_BP(NUM_BP), .AW(32)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bp_wr),
        .wr_idx   (bp_idx),
        .wr_addr  (bp_addr),
        .wr_en    (bp_en),
        .fetch_pc (if_pc),
        .mask     (mask_arm),
        .hit      (hit)
    );

    dbg_tag_pipe u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fetch_en && if_valid),
        .hit      (hit),
        .if_pc    (if_pc),
        .if_dslot (if_dslot),
        .if_br_pc (if_br_pc),
        .id_brk   (id_brk),
        .flush    (flush),
        .mem_q    (mem_q),
        .empty    (pipe_empty)
    );

    dbg_halt_fsm #(.RESET_PC(RESET_PC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_q     (mem_q),
        .empty     (pipe_empty),
        .if_valid  (if_valid),
        .pc_next   (pc_next),
        .run_req   (run_req),
        .step_req  (step_req),
        .fetch_en  (fetch_en),
        .flush     (flush),
        .mem_kill  (mem_kill),
        .halted    (halted),
        .resume_pc (resume_pc),
        .mask_arm  (mask_arm)
    );

endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fetch_en,
    input logic        if_valid,
    input logic        flush,
    input logic        mem_kill,
    input logic        halted,
    input logic [31:0] resume_pc,
    input logic        run_req,
    input logic        step_req,
    input logic        pipe_empty,
    input logic        mask_arm
);
    // R3: a blocked access always comes with a flush and a stopped fetch
    p_kill_flushes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_kill |-> (flush && !fetch_en));

    // R3: younger work is discarded, so no fetch during a flush
    p_flush_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !fetch_en);

    // R7: halt follows a cycle in which the tracked stages were empty
    p_halt_after_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(pipe_empty));

    // R8: while stopped and no request arrives, nothing moves
    p_halt_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !run_req && !step_req) |=> (halted && $stable(resume_pc)));

    // R8: halted core neither fetches nor flushes
    p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!fetch_en && !flush && !mem_kill));

    // R10: the exemption is spent by the first accepted fetch
    p_mask_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && if_valid && mask_arm) |=> !mask_arm);

endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_en   (fetch_en),
    .if_valid   (if_valid),
    .flush      (flush),
    .mem_kill   (mem_kill),
    .halted     (halted),
    .resume_pc  (resume_pc),
    .run_req    (run_req),
    .step_req   (step_req),
    .pipe_empty (pipe_empty),
    .mask_arm   (mask_arm)
);

// File: tb/dbg_halt_ctrl_test.sv
module dbg_halt_ctrl_test;

    localparam logic [31:0] RST_PC = 32'h0000_0040;
    localparam logic [31:0] NONE   = 32'hFFFF_FFF0;
    localparam int          WDOG   = 100000;

    typedef struct packed {
        logic [31:0] bp;
        logic        en;
        logic [31:0] br;
        logic [31:0] brk;
        logic [31:0] res;
        logic [3:0]  kills;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h120, 1'b1, NONE,     NONE,     32'h120, 4'd1, 4'd2},
        '{32'h124, 1'b1, 32'h120,  NONE,     32'h120, 4'd1, 4'd2},
        '{32'h110, 1'b0, NONE,     32'h130,  32'h134, 4'd0, 4'd3},
        '{32'h134, 1'b1, NONE,     32'h130,  32'h134, 4'd0, 4'd3},
        '{32'h130, 1'b1, NONE,     32'h134,  32'h130, 4'd1, 4'd2},
        '{32'h122, 1'b1, NONE,     NONE,     32'h120, 4'd1, 4'd2},
        '{32'h150, 1'b1, NONE,     32'h100,  32'h104, 4'd0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bp_wr = 1'b0;
    logic [1:0]  bp_idx = '0;
    logic [31:0] bp_addr = '0;
    logic        bp_en = 1'b0;
    logic        run_req = 1'b0;
    logic        step_req = 1'b0;
    logic        fetch_en, flush, mem_kill, halted;
    logic [31:0] resume_pc;

    logic [31:0] pcr = 32'h100;
    logic        b_id_v = 1'b0;
    logic [31:0] b_id_pc = '0;
    logic [31:0] br_pc = NONE;
    logic [31:0] brk_pc = NONE;
    logic        load = 1'b0;
    logic [31:0] load_pc = '0;
    int          kill_cnt = 0;
    int          fetch_cnt = 0;
    int          cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;

    logic        if_dslot, id_brk;
    assign if_dslot = (br_pc != NONE) && (pcr == br_pc + 32'd4);
    assign id_brk   = b_id_v && (b_id_pc == brk_pc);

    dbg_halt_ctrl #(.NUM_BP(4), .RESET_PC(RST_PC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bp_wr     (bp_wr),
        .bp_idx    (bp_idx),
        .bp_addr   (bp_addr),
        .bp_en     (bp_en),
        .if_valid  (1'b1),
        .if_pc     (pcr),
        .if_dslot  (if_dslot),
        .if_br_pc  (br_pc),
        .id_brk    (id_brk),
        .pc_next   (pcr),
        .run_req   (run_req),
        .step_req  (step_req),
        .fetch_en  (fetch_en),
        .flush     (flush),
        .mem_kill  (mem_kill),
        .halted    (halted),
        .resume_pc (resume_pc)
    );

    always #2 clk = ~clk;

    // Bench-side fetch and decode model of the pipeline
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (load) pcr <= load_pc;
        else if (fetch_en) pcr <= pcr + 32'd4;
        if (fetch_en && !flush) begin
            b_id_v  <= 1'b1;
            b_id_pc <= pcr;
        end else begin
            b_id_v <= 1'b0;
        end
        if (mem_kill) kill_cnt <= kill_cnt + 1;
        if (fetch_en) fetch_cnt <= fetch_cnt + 1;
        if (cyc == WDOG) begin
            n_fail <= n_fail + 1;
            $display("FAIL watchdog: run hung (act %0d cycles, exp < %0d)", cyc, WDOG);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_bp(input int idx, input logic [31:0] a, input logic e);
        @(negedge clk);
        bp_wr = 1'b1; bp_idx = 2'(idx); bp_addr = a; bp_en = e;
        @(negedge clk);
        bp_wr = 1'b0;
    endtask

    task automatic launch(input bit step, input logic [31:0] pc);
        @(negedge clk);
        load = 1'b1; load_pc = pc;
        if (step) step_req = 1'b1; else run_req = 1'b1;
        @(negedge clk);
        load = 1'b0; run_req = 1'b0; step_req = 1'b0;
    endtask

    task automatic wait_halt(output int lat);
        bit seen = 0;
        lat = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (seen) lat++;
            if (halted) break;
            if (flush) begin seen = 1; lat = 0; end
        end
    endtask

    initial begin
        int lat, k0, f0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 halted", 32'(halted), 32'd1);
        chk("R1 fetch_en", 32'(fetch_en), 32'd0);
        chk("R1 flush", 32'(flush), 32'd0);
        chk("R1 mem_kill", 32'(mem_kill), 32'd0);
        chk("R1 resume_pc", resume_pc, RST_PC);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R8: stays halted with no request
        chk("R8 halted idle", 32'(halted), 32'd1);
        chk("R8 resume idle", resume_pc, RST_PC);

        // Table: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            for (int j = 1; j < 4; j++) wr_bp(j, 32'h0, 1'b0);
            wr_bp(0, VECS[v].bp, VECS[v].en);
            br_pc = VECS[v].br; brk_pc = VECS[v].brk;
            k0 = kill_cnt;
            launch(0, 32'h100);
            wait_halt(lat);
            chk($sformatf("R4/R5/R6 resume v%0d", v), resume_pc, VECS[v].res);
            chk($sformatf("R2/R3/R6 kills v%0d", v), 32'(kill_cnt - k0), 32'(VECS[v].kills));
            chk($sformatf("R7 latency v%0d", v), 32'(lat), 32'(VECS[v].lat));
        end

        // R10: one-shot exemption after an address breakpoint
        wr_bp(0, 32'h200, 1'b1);
        br_pc = NONE; brk_pc = NONE;
        launch(0, 32'h1F8);
        wait_halt(lat);
        chk("R10 first stop", resume_pc, 32'h200);
        brk_pc = 32'h208;
        k0 = kill_cnt;
        launch(0, resume_pc);
        wait_halt(lat);
        chk("R10 passed breakpoint", resume_pc, 32'h20C);
        chk("R10 no kill on exempt fetch", 32'(kill_cnt - k0), 32'd0);
        brk_pc = NONE;
        launch(0, 32'h1F8);
        wait_halt(lat);
        chk("R10 matching re-enabled", resume_pc, 32'h200);

        // R9: single step from a breakpoint halt (exempt first fetch)
        f0 = fetch_cnt;
        k0 = kill_cnt;
        launch(1, resume_pc);
        wait_halt(lat);
        chk("R9 one fetch", 32'(fetch_cnt - f0), 32'd1);
        chk("R9 step resume", resume_pc, 32'h204);
        chk("R9 halted again", 32'(halted), 32'd1);
        chk("R9 no kill", 32'(kill_cnt - k0), 32'd0);

        // R8: run pulse leaves halt on its edge
        launch(0, 32'h300);
        chk("R8 left halt", 32'(halted), 32'd0);
        chk("R8 fetching", 32'(fetch_en), 32'd1);
        wr_bp(1, 32'h340, 1'b1);
        wait_halt(lat);
        chk("R2 second entry", resume_pc, 32'h340);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule